// File: doc/BRIEF.md
# Shared External Bus Arbiter

This block decides which of three bus masters owns a single set of external address, write-data and data-enable pins. The masters are a test controller, an auxiliary memory controller and a static memory controller, ranked in that order of priority. Each master raises a request and watches its grant. Only the master that currently owns the bus reaches the pins. Read data arriving from the pins is copied to every master without arbitration.

Ownership never moves in the middle of a transfer. A higher-priority request only withdraws the current owner's grant. The owner finishes its transfer, drops its request, and only then does the waiting master receive the bus. When the bus is idle, the static memory controller holds the grant, so its accesses start with no arbitration delay.

A bypass input hands the whole job to an external multiplexer. In bypass, requests are forwarded out of the block, grants come in from outside, and the internal pin drivers go quiet.

Top module: `ext_bus_arbiter`

## Requirements
- R1: Request and grant bit 0 belong to the test controller, bit 1 to the auxiliary controller and bit 2 to the static controller. When the bus is handed over, the lowest-numbered pending request wins.
- R2: After reset, and on the cycle after any cycle in which no request is raised (bypass low), only grant bit 2 is high.
- R3: A static-controller request raised while it already holds the default grant sees its grant high in that same cycle, with no arbitration delay.
- R4: If the owner requests in cycle t and a higher-priority request is also present in cycle t, the owner's grant is low from cycle t+1.
- R5: While a degranted owner keeps its request high, no grant is asserted and the pins keep showing that owner's outputs.
- R6: In the cycle after the degranted owner drops its request, the highest pending requester is granted. This gives a minimum request-to-grant latency of two cycles.
- R7: A lower-priority request never withdraws the grant of a higher-priority owner that is still requesting.
- R8: A degranted master that raises its request again is treated as a new requester. It is granted only when it is the highest pending request at the next handover.
- R9: pin_addr_o, pin_wdata_o and pin_den_n_o (active low) show the owning master's outputs. mst_rdata_o equals pin_rdata_i combinationally.
- R10: At most one grant bit is high in any cycle while bypass is low.
- R11: While bypass_i is high:
  - gnt_o equals ext_gnt_i;
  - ext_req_o equals req_i (ext_req_o is zero when bypass is low);
  - pin_den_n_o is 1 and the pin address and data are zero;
  - once bypass falls, the grant is at the default (bit 2) immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bypass_i | input | 1 | High: an external multiplexer arbitrates |
| req_i | input | N_MST | Bus requests, bit 0 highest priority |
| gnt_o | output | N_MST | Bus grants |
| ext_req_o | output | N_MST | Requests forwarded to the external multiplexer |
| ext_gnt_i | input | N_MST | Grants from the external multiplexer |
| mst_addr_i | input | N_MST*ADDR_W | Per-master address, master k at slice k |
| mst_wdata_i | input | N_MST*DATA_W | Per-master write data |
| mst_den_n_i | input | N_MST | Per-master data enable, active low |
| pin_addr_o | output | ADDR_W | External address pins |
| pin_wdata_o | output | DATA_W | External write-data pins |
| pin_den_n_o | output | 1 | External data enable, active low |
| pin_rdata_i | input | DATA_W | Read data from the pins |
| mst_rdata_o | output | DATA_W | Read data broadcast to all masters |

## Verification
The internal state is an owner index plus a flag that says whether the owner is still holding the bus after losing its grant. These faults each show up within one clock cycle:
- A wrong owner index appears on the pin address, which the bench gives a distinct value per master.
- A lost flag shows up as a grant that rises while the degranted master still requests.
- A stuck flag shows up as a missing grant one cycle after the release.

The bench exercises both the handover latency and the pin contents on every grant change.

// File: rtl/ebus_pkg.sv
// Shared definitions for the external bus arbiter.
// Assumes request index 0 carries the highest priority.
package ebus_pkg;

    // Arbiter phase: HOLD = owner granted, DRAIN = owner degranted but still busy
    typedef enum logic {
        ARB_HOLD  = 1'b0,
        ARB_DRAIN = 1'b1
    } arb_phase_e;

endpackage

// File: rtl/ebus_prio_pick.sv
// Fixed-priority picker: reports whether any request is raised and the
// lowest-numbered (highest-priority) one. Assumes N_MST >= 2.
module ebus_prio_pick #(
    parameter int N_MST = 3,
    localparam int IDX_W = $clog2(N_MST)
) (
    input  logic [N_MST-1:0] req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from lowest priority upward so the highest-priority request wins
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int k = N_MST - 1; k >= 0; k--) begin
            if (req_i[k]) idx_o = IDX_W'(k);
        end
    end

endmodule

// File: rtl/ebus_arb_fsm.sv
// Ownership tracker. Keeps the owning master and whether it is degranted
// and finishing its transfer. Hands the bus over only after the owner
// drops its request. The default owner is the last (lowest-priority) master.
// Assumes requests are synchronous to clk.
module ebus_arb_fsm
    import ebus_pkg::*;
#(
    parameter int N_MST = 3,
    localparam int IDX_W = $clog2(N_MST)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass_i,
    input  logic [N_MST-1:0] req_i,
    input  logic             hi_any_i,
    input  logic [IDX_W-1:0] hi_idx_i,
    output logic [N_MST-1:0] gnt_o,
    output logic [IDX_W-1:0] own_o
);

    localparam logic [IDX_W-1:0] DEF_IDX = IDX_W'(N_MST - 1);
    localparam logic [N_MST-1:0] DEF_GNT = N_MST'(1) << (N_MST - 1);

    arb_phase_e       phase_q, phase_d;
    logic [IDX_W-1:0] own_q, own_d;
    logic             own_req;
    logic             higher_req;
    logic [IDX_W-1:0] next_own;

    // Pick out the owner's own request line
    always_comb begin
        own_req = 1'b0;
        for (int k = 0; k < N_MST; k++) begin
            if (own_q == IDX_W'(k)) own_req = req_i[k];
        end
    end

    // Next owner and phase: degrant on higher request, hand over on release
    always_comb begin
        higher_req = hi_any_i && (hi_idx_i < own_q);
        next_own   = hi_any_i ? hi_idx_i : DEF_IDX;
        phase_d    = phase_q;
        own_d      = own_q;
        case (phase_q)
            ARB_HOLD: begin
                if (!own_req)        own_d   = next_own;
                else if (higher_req) phase_d = ARB_DRAIN;
            end
            default: begin
                if (!own_req) begin
                    own_d   = next_own;
                    phase_d = ARB_HOLD;
                end
            end
        endcase
    end

    // State register; bypass parks the arbiter at the default owner
    always_ff @(posedge clk) begin
        if (!rst_n || bypass_i) begin
            phase_q <= ARB_HOLD;
            own_q   <= DEF_IDX;
        end else begin
            phase_q <= phase_d;
            own_q   <= own_d;
        end
    end

    // Grant decode: only the owner, and only while not draining
    always_comb begin
        for (int k = 0; k < N_MST; k++) begin
            gnt_o[k] = (phase_q == ARB_HOLD) && (own_q == IDX_W'(k));
        end
    end

    assign own_o = own_q;

    // R2: a cycle with no request leaves the default grant next cycle
    assert_idle_default_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_i && req_i == '0) |=> (gnt_o == DEF_GNT));

    // R5: a degranted owner still requesting keeps every grant low
    assert_drain_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_i && gnt_o == '0 && own_req) |=> (gnt_o == '0));

    // R6: release during drain grants the highest pending requester next cycle
    assert_handover_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_i && gnt_o == '0 && !own_req && hi_any_i)
        |=> (gnt_o == (N_MST'(1) << $past(hi_idx_i))));

    // Per-master degrant and keep rules
    for (genvar g = 0; g < N_MST; g++) begin : g_chk
        logic above;
        if (g == 0) begin : g_top
            assign above = 1'b0;
        end else begin : g_low
            assign above = |req_i[g-1:0];
        end

        // R4: owner requesting with a higher request present loses its grant
        assert_degrant_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!bypass_i && gnt_o[g] && req_i[g] && above) |=> !gnt_o[g]);

        // R7: with no higher request, a requesting owner keeps its grant
        assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!bypass_i && gnt_o[g] && req_i[g] && !above) |=> gnt_o[g]);
    end

endmodule

// File: rtl/ebus_pin_mux.sv
// Pin multiplexer: routes the owning master's address, write data and
// active-low data enable onto the external pins. In bypass the pins idle
// (zero address/data, data enable inactive). Assumes sel_i < N_MST.
module ebus_pin_mux #(
    parameter int N_MST  = 3,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(N_MST)
) (
    input  logic                    bypass_i,
    input  logic [IDX_W-1:0]        sel_i,
    input  logic [N_MST*ADDR_W-1:0] mst_addr_i,
    input  logic [N_MST*DATA_W-1:0] mst_wdata_i,
    input  logic [N_MST-1:0]        mst_den_n_i,
    output logic [ADDR_W-1:0]       pin_addr_o,
    output logic [DATA_W-1:0]       pin_wdata_o,
    output logic                    pin_den_n_o
);

    logic [ADDR_W-1:0] addr_a  [N_MST];
    logic [DATA_W-1:0] wdata_a [N_MST];

    // Unpack the flat per-master buses
    for (genvar g = 0; g < N_MST; g++) begin : g_unpack
        assign addr_a[g]  = mst_addr_i[g*ADDR_W +: ADDR_W];
        assign wdata_a[g] = mst_wdata_i[g*DATA_W +: DATA_W];
    end

    // Select the owner's signals, or idle the pins in bypass
    always_comb begin
        pin_addr_o  = '0;
        pin_wdata_o = '0;
        pin_den_n_o = 1'b1;
        if (!bypass_i) begin
            for (int k = 0; k < N_MST; k++) begin
                if (sel_i == IDX_W'(k)) begin
                    pin_addr_o  = addr_a[k];
                    pin_wdata_o = wdata_a[k];
                    pin_den_n_o = mst_den_n_i[k];
                end
            end
        end
    end

endmodule

// File: rtl/ext_bus_arbiter.sv
// Shared external bus arbiter top. Fixed priority, with master 0 highest.
// Release-based handover and a default grant to the last master.
// Optional bypass to an external multiplexer.
// Assumes all inputs are synchronous to clk.
module ext_bus_arbiter #(
    parameter int N_MST  = 3,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(N_MST)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bypass_i,
    input  logic [N_MST-1:0]        req_i,
    output logic [N_MST-1:0]        gnt_o,
    output logic [N_MST-1:0]        ext_req_o,
    input  logic [N_MST-1:0]        ext_gnt_i,
    input  logic [N_MST*ADDR_W-1:0] mst_addr_i,
    input  logic [N_MST*DATA_W-1:0] mst_wdata_i,
    input  logic [N_MST-1:0]        mst_den_n_i,
    output logic [ADDR_W-1:0]       pin_addr_o,
    output logic [DATA_W-1:0]       pin_wdata_o,
    output logic                    pin_den_n_o,
    input  logic [DATA_W-1:0]       pin_rdata_i,
    output logic [DATA_W-1:0]       mst_rdata_o
);

    logic             hi_any;
    logic [IDX_W-1:0] hi_idx;
    logic [N_MST-1:0] arb_gnt;
    logic [IDX_W-1:0] own_idx;

    ebus_prio_pick #(.N_MST(N_MST)) u_pick (
        .req_i (req_i),
        .any_o (hi_any),
        .idx_o (hi_idx)
    );

    ebus_arb_fsm #(.N_MST(N_MST)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bypass_i (bypass_i),
        .req_i    (req_i),
        .hi_any_i (hi_any),
        .hi_idx_i (hi_idx),
        .gnt_o    (arb_gnt),
        .own_o    (own_idx)
    );

    ebus_pin_mux #(.N_MST(N_MST), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .bypass_i    (bypass_i),
        .sel_i       (own_idx),
        .mst_addr_i  (mst_addr_i),
        .mst_wdata_i (mst_wdata_i),
        .mst_den_n_i (mst_den_n_i),
        .pin_addr_o  (pin_addr_o),
        .pin_wdata_o (pin_wdata_o),
        .pin_den_n_o (pin_den_n_o)
    );

    // Grant source and request forwarding depend on the bypass mode
    always_comb begin
        gnt_o     = bypass_i ? ext_gnt_i : arb_gnt;
        ext_req_o = bypass_i ? req_i : '0;
    end

    // Inbound data reaches every master unarbitrated
    assign mst_rdata_o = pin_rdata_i;

endmodule

// File: tb/ext_bus_arbiter_bench.sv
`timescale 1ns/1ps
module ext_bus_arbiter_bench;

    localparam int N = 3;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bypass = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  gnt;
    logic [N-1:0]  ext_req;
    logic [N-1:0]  ext_gnt = '0;
    logic [N*AW-1:0] maddr = {16'h2C2C, 16'h1B1B, 16'h0A0A};
    logic [N*DW-1:0] mwdata = {8'hC2, 8'hB1, 8'hA0};
    logic [N-1:0]  mden_n = 3'b010;
    logic [AW-1:0] paddr;
    logic [DW-1:0] pwdata;
    logic          pden_n;
    logic [DW-1:0] prdata = '0;
    logic [DW-1:0] mrdata;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ext_bus_arbiter #(.N_MST(N), .ADDR_W(AW), .DATA_W(DW)) u_ext_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .bypass_i(bypass), .req_i(req), .gnt_o(gnt),
        .ext_req_o(ext_req), .ext_gnt_i(ext_gnt), .mst_addr_i(maddr),
        .mst_wdata_i(mwdata), .mst_den_n_i(mden_n), .pin_addr_o(paddr),
        .pin_wdata_o(pwdata), .pin_den_n_o(pden_n), .pin_rdata_i(prdata),
        .mst_rdata_o(mrdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req = '0; bypass = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check("R2 reset grant", 32'(gnt), 32'h4);
        check("R9 reset pin addr", 32'(paddr), 32'h2C2C);
        check("R11 no forward", 32'(ext_req), 32'h0);
    endtask

    task automatic t_static_immediate();
        req = 3'b100; #1;
        check("R3 same-cycle grant", 32'(gnt), 32'h4);
        tick();
        check("R3 grant kept", 32'(gnt), 32'h4);
    endtask

    task automatic t_preempt_latency();
        req = 3'b110; tick();
        check("R4 static degranted", 32'(gnt), 32'h0);
        check("R5 pins still static", 32'(paddr), 32'h2C2C);
        tick();
        check("R5 no grant while busy", 32'(gnt), 32'h0);
        req = 3'b010; tick();
        check("R6 aux granted after release", 32'(gnt), 32'h2);
        check("R9 pins aux addr", 32'(paddr), 32'h1B1B);
        check("R9 pins aux data", 32'(pwdata), 32'hB1);
        check("R9 pins aux den", 32'(pden_n), 32'h1);
        req = 3'b000; tick();
        check("R2 idle default", 32'(gnt), 32'h4);
        req = 3'b100; tick();
        req = 3'b110; tick();
        check("R10 at most one grant", 32'($countones(gnt) <= 1), 32'h1);
        req = 3'b010; tick();
        check("R6 two-cycle latency", 32'(gnt), 32'h2);
    endtask

    task automatic t_reassert();
        req = 3'b110; tick();
        check("R8 reasserted waits", 32'(gnt), 32'h2);
        tick();
        check("R7 aux kept", 32'(gnt), 32'h2);
        req = 3'b100; tick();
        check("R8 static regranted", 32'(gnt), 32'h4);
        check("R9 pins static", 32'(paddr), 32'h2C2C);
    endtask

    task automatic t_test_owner();
        req = 3'b000; tick();
        req = 3'b001; tick();
        check("R1 test granted from idle", 32'(gnt), 32'h1);
        check("R9 pins test den", 32'(pden_n), 32'h0);
        req = 3'b011; tick(); tick();
        check("R7 lower does not preempt", 32'(gnt), 32'h1);
        req = 3'b010; tick();
        check("R6 aux after test release", 32'(gnt), 32'h2);
        req = 3'b011; tick();
        check("R4 aux degranted by test", 32'(gnt), 32'h0);
        check("R5 pins aux while draining", 32'(paddr), 32'h1B1B);
        req = 3'b001; tick();
        check("R1 test granted", 32'(gnt), 32'h1);
        check("R9 pins test addr", 32'(paddr), 32'h0A0A);
    endtask

    task automatic t_priority_pick();
        req = 3'b000; tick();
        req = 3'b100; tick();
        req = 3'b111; tick();
        check("R4 static degranted", 32'(gnt), 32'h0);
        req = 3'b011; tick();
        check("R1 highest of two waiting", 32'(gnt), 32'h1);
    endtask

    task automatic t_rdata();
        prdata = 8'h5A; #1;
        check("R9 read broadcast", 32'(mrdata), 32'h5A);
        prdata = 8'hA5; #1;
        check("R9 read broadcast 2", 32'(mrdata), 32'hA5);
    endtask

    task automatic t_bypass();
        bypass = 1'b1; ext_gnt = 3'b010; req = 3'b101; #1;
        check("R11 external grant", 32'(gnt), 32'h2);
        check("R11 forwarded req", 32'(ext_req), 32'h5);
        check("R11 den inactive", 32'(pden_n), 32'h1);
        check("R11 addr idle", 32'(paddr), 32'h0);
        tick(); tick();
        bypass = 1'b0; ext_gnt = '0; req = '0; #1;
        check("R11 default after bypass", 32'(gnt), 32'h4);
        check("R11 no forward after", 32'(ext_req), 32'h0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_static_immediate();
        t_preempt_latency();
        t_reassert();
        t_test_owner();
        t_priority_pick();
        t_rdata();
        t_bypass();
        tick();
        summary();
        $finish;
    end

endmodule